// File: doc/BRIEF.md
# Graphics Write Masking Datapath

This block forms the write side of a graphics memory for one open row of 32-bit words. For each write it decides which bits are written and what data goes to them. It holds two 32-bit registers, a bit-mask register and a color register. Each is loaded by a special register-load command, and each is selected by a single address bit.

A normal write beat passes the DQ data through. Its per-bit enables are the mask register ANDed with the inverted DQM byte mask. The mask register takes part only when the row was opened with write-per-bit. A block write writes one aligned group of eight columns in a single cycle. Every column receives the color register contents. Which columns and bytes are written is taken from the DQ bits of that cycle and then gated by the same mask and DQM layers. Command decoding and the storage array lie outside the block. The outputs are combinational in the command cycle, and register loads take effect at the next clock edge.

Top module: `gfx_wmask_top`

## Requirements
- R1: After reset, both the mask register and the color register hold all zeros.
- R2: A load command (cmd 1) whose address equals exactly bit 5 set loads the mask register from DQ. The new value is visible from the next clock edge.
- R3: A load command whose address equals exactly bit 6 set loads the color register from DQ. The new value is visible from the next clock edge.
- R4: A load command with any other address pattern changes neither register. This includes zero, extra set bits, and both selecting bits set together.
- R5: On a write (cmd 2) without write-per-bit, wr_data_o equals DQ. Bit i of wr_bit_en_o is set exactly when DQM bit i/8 is low.
- R6: On a write with write-per-bit, wr_bit_en_o is additionally ANDed with the mask register.
- R7: On a block write (cmd 3), blk_data_o equals the color register and blk_base_o equals address bits 8 to 3. Address bits 2 to 0 have no effect.
- R8: On a block write, DQ bit 8*b+c enables byte b of column c. Column c's enables sit at blk_bit_en_o[32*c +: 32].
- R9: Block-write enables are also gated by the inverted DQM. When write-per-bit is on, they are further gated by the mask register.
- R10: When no write command is present, wr_valid_o and wr_bit_en_o are zero. When no block write is present, blk_valid_o, blk_col_en_o and blk_bit_en_o are zero.
- R11: blk_col_en_o[c] is set exactly when any bit of column c is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 2 | 0 idle, 1 register load, 2 write, 3 block write |
| addr_i | input | 9 | Column / load-select address |
| dq_i | input | 32 | Data, or block-write column/byte enables |
| dqm_i | input | 4 | Byte mask, high masks the byte |
| wpb_i | input | 1 | Open row uses write-per-bit |
| wr_valid_o | output | 1 | Normal write beat present |
| wr_bit_en_o | output | 32 | Per-bit write enable |
| wr_data_o | output | 32 | Write data |
| blk_valid_o | output | 1 | Block write present |
| blk_base_o | output | 6 | Column group (address bits 8..3) |
| blk_col_en_o | output | 8 | Column has any enabled bit |
| blk_bit_en_o | output | 256 | Per-column per-bit enables |
| blk_data_o | output | 32 | Color data for all columns |

## Verification
The bench builds the block with its default parameters: 32-bit words, eight block columns, a 9-bit address, and select bits 5 and 6. With these values both select bits can be exercised. Near-miss addresses that combine a select bit with low or high bits can be tried, and every one of the 32 column/byte gate bits maps onto a distinct byte of the 256-bit block enable. The bench also covers write-per-bit on and off for both write kinds, so each masking layer is exercised alone and in combination.

// File: rtl/gfx_wm_pkg.sv
package gfx_wm_pkg;
  parameter int unsigned DQ_W     = 32;
  parameter int unsigned BYTE_W   = 8;
  parameter int unsigned NBYTES   = DQ_W / BYTE_W;
  parameter int unsigned BLK_COLS = 8;

  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_LDSPEC = 2'd1,
    CMD_WRITE  = 2'd2,
    CMD_BLKWR  = 2'd3
  } cmd_e;

  // Widen one flag per byte to a full-width bit vector.
  function automatic logic [DQ_W-1:0] byte_expand(input logic [NBYTES-1:0] sel);
    logic [DQ_W-1:0] r;
    for (int b = 0; b < NBYTES; b++) r[b*BYTE_W +: BYTE_W] = {BYTE_W{sel[b]}};
    return r;
  endfunction

  // Byte gates of one block-write column: DQ bit BLK_COLS*b + col.
  function automatic logic [NBYTES-1:0] col_bytes(input logic [DQ_W-1:0] dq,
                                                  input int unsigned col);
    logic [NBYTES-1:0] r;
    for (int b = 0; b < NBYTES; b++) r[b] = dq[b*BLK_COLS + col];
    return r;
  endfunction
endpackage

// File: rtl/gfx_wm_regs.sv
module gfx_wm_regs
  import gfx_wm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned MASK_SEL  = 5,
  parameter int unsigned COLOR_SEL = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq,
  output logic [DQ_W-1:0]   mask_q,
  output logic [DQ_W-1:0]   color_q,
  output logic              ld_mask,
  output logic              ld_color
);
  localparam logic [ADDR_W-1:0] MASK_PAT  = ADDR_W'(1) << MASK_SEL;
  localparam logic [ADDR_W-1:0] COLOR_PAT = ADDR_W'(1) << COLOR_SEL;

  assign ld_mask  = ld_cmd && (addr == MASK_PAT);
  assign ld_color = ld_cmd && (addr == COLOR_PAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      color_q <= '0;
    end else begin
      if (ld_mask)  mask_q  <= dq;
      if (ld_color) color_q <= dq;
    end
  end

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mask |=> mask_q == $past(dq));
  // R3
  color_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_color |=> color_q == $past(dq));
  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mask |=> $stable(mask_q));
  // R4
  color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_color |=> $stable(color_q));
  // R4
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_mask && ld_color));
endmodule

// File: rtl/gfx_wm_lane.sv
module gfx_wm_lane
  import gfx_wm_pkg::*;
(
  input  logic              enable,
  input  logic              wpb,
  input  logic [DQ_W-1:0]   mask_q,
  input  logic [NBYTES-1:0] dqm,
  input  logic [NBYTES-1:0] byte_gate,
  output logic [DQ_W-1:0]   bit_en
);
  logic [DQ_W-1:0] wpb_layer;
  logic [DQ_W-1:0] byte_layer;

  always_comb begin
    wpb_layer  = wpb ? mask_q : '1;
    byte_layer = byte_expand(~dqm & byte_gate);
    bit_en     = enable ? (wpb_layer & byte_layer) : '0;
  end
endmodule

// File: rtl/gfx_wmask_top.sv
module gfx_wmask_top
  import gfx_wm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned MASK_SEL  = 5,
  parameter int unsigned COLOR_SEL = 6,
  localparam int unsigned COL_LSB  = $clog2(BLK_COLS),
  localparam int unsigned BASE_W   = ADDR_W - COL_LSB
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cmd_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DQ_W-1:0]          dq_i,
  input  logic [NBYTES-1:0]        dqm_i,
  input  logic                     wpb_i,
  output logic                     wr_valid_o,
  output logic [DQ_W-1:0]          wr_bit_en_o,
  output logic [DQ_W-1:0]          wr_data_o,
  output logic                     blk_valid_o,
  output logic [BASE_W-1:0]        blk_base_o,
  output logic [BLK_COLS-1:0]      blk_col_en_o,
  output logic [BLK_COLS*DQ_W-1:0] blk_bit_en_o,
  output logic [DQ_W-1:0]          blk_data_o
);
  cmd_e            cmd;
  logic            is_load, is_write, is_blk;
  logic [DQ_W-1:0] mask_q, color_q;
  logic            ld_mask, ld_color;

  assign cmd      = cmd_e'(cmd_i);
  assign is_load  = (cmd == CMD_LDSPEC);
  assign is_write = (cmd == CMD_WRITE);
  assign is_blk   = (cmd == CMD_BLKWR);

  gfx_wm_regs #(.ADDR_W(ADDR_W), .MASK_SEL(MASK_SEL), .COLOR_SEL(COLOR_SEL)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_cmd(is_load), .addr(addr_i), .dq(dq_i),
    .mask_q(mask_q), .color_q(color_q), .ld_mask(ld_mask), .ld_color(ld_color)
  );

  gfx_wm_lane u_wr_lane (
    .enable(is_write), .wpb(wpb_i), .mask_q(mask_q), .dqm(dqm_i),
    .byte_gate('1), .bit_en(wr_bit_en_o)
  );

  assign wr_valid_o = is_write;
  assign wr_data_o  = dq_i;

  for (genvar c = 0; c < BLK_COLS; c++) begin : g_col
    logic [DQ_W-1:0] col_en;
    gfx_wm_lane u_blk_lane (
      .enable(is_blk), .wpb(wpb_i), .mask_q(mask_q), .dqm(dqm_i),
      .byte_gate(col_bytes(dq_i, c)), .bit_en(col_en)
    );
    assign blk_bit_en_o[c*DQ_W +: DQ_W] = col_en;
    assign blk_col_en_o[c]              = |col_en;
  end

  assign blk_valid_o = is_blk;
  assign blk_base_o  = is_blk ? addr_i[ADDR_W-1:COL_LSB] : '0;
  assign blk_data_o  = is_blk ? color_q : '0;

  // R10
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_o |-> wr_bit_en_o == '0);
  // R10
  blk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid_o |-> (blk_col_en_o == '0 && blk_bit_en_o == '0));
  // R5
  dqm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bit_en_o & byte_expand(dqm_i)) == '0);
  // R6
  wpb_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wpb_i) |-> (wr_bit_en_o & ~mask_q) == '0);
  // R7
  blk_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid_o |-> blk_data_o == color_q);
  // R9
  blk_dqm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_bit_en_o[DQ_W-1:0] & byte_expand(dqm_i)) == '0);
endmodule

// File: tb/gfx_wmask_top_bench.sv
module gfx_wmask_top_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [1:0]   cmd_i = 0;
  logic [8:0]   addr_i = 0;
  logic [31:0]  dq_i = 0;
  logic [3:0]   dqm_i = 0;
  logic         wpb_i = 0;
  logic         wr_valid_o, blk_valid_o;
  logic [31:0]  wr_bit_en_o, wr_data_o, blk_data_o;
  logic [5:0]   blk_base_o;
  logic [7:0]   blk_col_en_o;
  logic [255:0] blk_bit_en_o;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] cur_mask = 0, cur_color = 0;

  always #2 clk = ~clk;

  gfx_wmask_top u_gfx_wmask_top (.*);

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] c, logic [8:0] a, logic [31:0] d, logic [3:0] m, logic w);
    @(negedge clk);
    cmd_i = c; addr_i = a; dq_i = d; dqm_i = m; wpb_i = w;
    #1;
  endtask

  function automatic logic [31:0] exp_en(logic [31:0] mk, logic w, logic [3:0] m, logic [3:0] g);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (!w || mk[i]) && !m[i/8] && g[i/8];
    return r;
  endfunction

  task automatic load(logic [8:0] a, logic [31:0] d);
    drive(2'd1, a, d, 4'h0, 0);
    drive(2'd0, 9'h0, 32'h0, 4'h0, 0);
  endtask

  task automatic check_regs(string req);
    drive(2'd2, 9'h0, 32'h1234_5678, 4'h0, 1);
    chk(req, wr_bit_en_o, cur_mask);
    drive(2'd3, 9'h0, 32'hFFFF_FFFF, 4'h0, 0);
    chk(req, blk_data_o, cur_color);
  endtask

  task automatic t_reset();
    check_regs("R1");
  endtask

  task automatic t_loads();
    cur_mask = 32'hF0F0_3C5A; load(9'h020, cur_mask); check_regs("R2");
    cur_color = 32'hCAFE_0042; load(9'h040, cur_color); check_regs("R3");
  endtask

  task automatic t_bad_loads();
    load(9'h021, 32'h1111_1111);
    load(9'h060, 32'h2222_2222);
    load(9'h000, 32'h3333_3333);
    load(9'h0A0, 32'h4444_4444);
    load(9'h140, 32'h5555_5555);
    check_regs("R4");
  endtask

  task automatic t_writes();
    drive(2'd2, 9'h013, 32'hDEAD_BEEF, 4'b0101, 0);
    chk("R5", wr_data_o, 32'hDEAD_BEEF);
    chk("R5", wr_bit_en_o, exp_en(cur_mask, 0, 4'b0101, 4'hF));
    chk("R5", wr_valid_o, 1);
    drive(2'd2, 9'h013, 32'h0, 4'b1000, 1);
    chk("R6", wr_bit_en_o, exp_en(cur_mask, 1, 4'b1000, 4'hF));
  endtask

  task automatic t_block(logic [8:0] a, logic [31:0] d, logic [3:0] m, logic w, string req);
    logic [255:0] e;
    logic [7:0] ce;
    drive(2'd3, a, d, m, w);
    for (int c = 0; c < 8; c++) begin
      logic [3:0] g;
      for (int b = 0; b < 4; b++) g[b] = d[8*b + c];
      e[32*c +: 32] = exp_en(cur_mask, w, m, g);
      ce[c] = |e[32*c +: 32];
    end
    chk(req, blk_bit_en_o, e);
    chk("R11", blk_col_en_o, ce);
    chk("R7", blk_data_o, cur_color);
    chk("R7", blk_base_o, a[8:3]);
  endtask

  task automatic t_idle();
    drive(2'd0, 9'h1FF, 32'hFFFF_FFFF, 4'h0, 1);
    chk("R10", {wr_valid_o, blk_valid_o, blk_col_en_o}, 0);
    chk("R10", wr_bit_en_o, 0);
    chk("R10", blk_bit_en_o, 0);
    drive(2'd1, 9'h1FF, 32'hFFFF_FFFF, 4'h0, 1);
    chk("R10", {wr_bit_en_o, blk_bit_en_o}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_loads();
    t_bad_loads();
    t_writes();
    t_block(9'h1AD, 32'h8001_2440, 4'h0, 0, "R8");
    t_block(9'h1A8, 32'hFFFF_FFFF, 4'h0, 0, "R8");
    t_block(9'h0C7, 32'hFFFF_FFFF, 4'b0110, 0, "R9");
    t_block(9'h0C1, 32'h0F0F_F00F, 4'b0001, 1, "R9");
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule